// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port run on clocks that need not be related. Words enter on write-clock edges and leave on read-clock edges. Both enables are active low. A write is refused while the buffer is full, and a read is refused while it is empty. Five status outputs report the fill level. Two of them are full and empty. The other three are almost-full, almost-empty and more-than-half-full. The almost-full and almost-empty thresholds come from two 12-bit offset registers. Those registers reset to a value that depends on the depth.

A load strobe, shared by both sides, turns the data ports toward the offset registers. A write transfer made with the strobe low stores the low twelve input bits into an offset register and leaves the buffer memory alone. A read transfer made with the strobe low shows an offset on the low twelve output bits and does not remove a word. An internal toggle picks the target, empty offset first and then full offset. A separate toggle on each side does this.

A mode input chooses between two read behaviours. In standard mode a read strobe moves the next word into the output register. In fall-through mode the oldest word appears on the outputs without any strobe. In that mode the two main flags become active-low ready indications. An output-enable input qualifies the data outputs.

Top module: `dcfifo_progflag`

## Requirements
- R1: While either reset is high, and in the cycle after both are released, the outputs show the idle state in standard mode. That state is wflag_n=1, afull_n=1, half_n=1, rflag_n=0, aempty_n=0 and q=0.
- R2: A rising write-clock edge with wr_en_n=0 and load_n=1 stores din, unless the buffer already holds DEPTH words. A word offered while the buffer is full is dropped, and it is never read out later.
- R3: In standard mode, a rising read-clock edge with rd_en_n=0 and load_n=1 loads the oldest word into q, provided a word is present. With rd_en_n=1, or with the buffer empty, q keeps its value. In this mode rflag_n is 1 exactly while the read side sees at least one stored word.
- R4: Words leave in the order in which they were written.
- R5: In standard mode, wflag_n is 0 exactly while the write side counts DEPTH stored words. It returns to 1 once reads reach the write side.
- R6: half_n is 0 while the write side counts more than DEPTH/2 stored words. With exactly DEPTH/2 words it is 1.
- R7: afull_n is 0 while the free space seen by the write side is less than or equal to the full offset.
- R8: aempty_n is 0 while the fill level seen by the read side is less than or equal to the empty offset. In fall-through mode that level includes a word waiting on q.
- R9: After reset both offsets hold 31 when DEPTH ≤ 256, 63 when DEPTH ≤ 512, and 127 for larger depths.
- R10: A write-clock edge with wr_en_n=0 and load_n=0 stores din[11:0] into an offset register and leaves the memory untouched. The first such load after reset goes to the empty offset, the next to the full offset, and the order then keeps alternating.
- R11: In standard mode, a read-clock edge with rd_en_n=0 and load_n=0 shows an offset on q[11:0], with q[17:12]=0. The empty offset is shown first, then the full offset, alternating. No word is removed. The next plain read puts memory data back on q.
- R12: In fall-through mode, rflag_n is 0 while a valid word waits on q, and that word appears without a read strobe. A read strobe replaces it with the next word, or sets rflag_n to 1 if none is left. wflag_n is 0 while the write side has room and 1 when it is full.
- R13: With oe_n=1, q reads all zero and q_en is 0. With oe_n=0, q_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data; the low 12 bits are used for offset loads |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low offset-register access strobe, shared by both sides |
| fwft | input | 1 | 0 = standard mode, 1 = fall-through mode |
| oe_n | input | 1 | Active-low output enable |
| q | output | 18 | Read data or offset readback; zero while disabled |
| q_en | output | 1 | High while q is driven |
| wflag_n | output | 1 | Standard: low when full. Fall-through: low when there is room |
| rflag_n | output | 1 | Standard: low when empty. Fall-through: low when a word waits on q |
| half_n | output | 1 | Low when more than half full |
| aempty_n | output | 1 | Low when almost empty |
| afull_n | output | 1 | Low when almost full |

## Verification
The bench builds the main instance with DEPTH=256. At that depth the default offset is 31, so the bench can fill the buffer completely. Along the way it checks the exact transitions at 128/129 words (half), 224/225 words (almost full), 256 words (full) and 32/31 words while draining (almost empty). A second instance with DEPTH=512 and all other inputs idle confirms the 63 default through the offset readback path. Both instances take both clocks from one bench clock. This makes the two-edge synchroniser delay fixed, so flag timing after a write or a read is known when each check samples.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic over_half;
    } wr_status_t;

    typedef struct packed {
        logic has_data;
        logic almost_empty;
        logic out_valid;
    } rd_status_t;

    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;

    // Offset loaded at reset, chosen by buffer depth
    function automatic int reset_offset(input int depth);
        if (depth <= 256) return 31;
        if (depth <= 512) return 63;
        return 127;
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
    endfunction

endpackage

// File: rtl/fifo_pf_sync2.sv
module fifo_pf_sync2 #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_pf_ram.sv
module fifo_pf_ram #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_pf_wside.sv
module fifo_pf_wside
    import fifo_pf_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_n,
    input  logic             load_n,
    input  logic [DW-1:0]    din,
    input  logic [AW:0]      rgray_s,
    output logic             mem_we,
    output logic [AW-1:0]    waddr,
    output logic [AW:0]      wgray,
    output logic [AW:0]      wbin,
    output logic [AW:0]      level,
    output wr_status_t       st,
    output logic [OFS_W-1:0] ofs_e,
    output logic [OFS_W-1:0] ofs_f
);
    localparam int PW = AW + 1;
    localparam int CW = (PW > OFS_W) ? PW : OFS_W;
    localparam logic [OFS_W-1:0] OFS_INIT = OFS_W'(reset_offset(DEPTH));

    logic [PW-1:0] rbin_s;
    logic [PW-1:0] free_cnt;
    logic [PW-1:0] wbin_nxt;
    logic          push;
    logic          ofs_wr;
    ofs_sel_e      sel;

    // Gray to binary: each bit is the parity of itself and all higher bits
    for (genvar i = 0; i < PW; i++) begin : g_dec
        assign rbin_s[i] = ^rgray_s[PW-1:i];
    end

    assign level    = wbin - rbin_s;
    assign free_cnt = PW'(DEPTH) - level;

    always_comb begin
        st.full        = (level == PW'(DEPTH));
        st.almost_full = (CW'(free_cnt) <= CW'(ofs_f));
        st.over_half   = (level > PW'(DEPTH / 2));
    end

    assign push     = !wr_en_n && load_n && !st.full;
    assign ofs_wr   = !wr_en_n && !load_n;
    assign wbin_nxt = wbin + PW'(1);
    assign mem_we   = push;
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_e <= OFS_INIT;
            ofs_f <= OFS_INIT;
            sel   <= SEL_EMPTY_OFS;
        end else if (ofs_wr) begin
            if (sel == SEL_EMPTY_OFS) ofs_e <= din[OFS_W-1:0];
            else                      ofs_f <= din[OFS_W-1:0];
            sel <= next_sel(sel);
        end
    end
endmodule

// File: rtl/fifo_pf_rside.sv
module fifo_pf_rside
    import fifo_pf_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en_n,
    input  logic             load_n,
    input  logic             fwft,
    input  logic [AW:0]      wgray_s,
    input  logic [DW-1:0]    rdata,
    input  logic [OFS_W-1:0] ofs_e,
    input  logic [OFS_W-1:0] ofs_f,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rgray,
    output logic [AW:0]      rbin,
    output logic [AW:0]      level,
    output logic [DW-1:0]    dreg,
    output logic             show_ofs,
    output logic [OFS_W-1:0] rb_val,
    output rd_status_t       st
);
    localparam int PW = AW + 1;
    localparam int CW = (PW > OFS_W) ? PW : OFS_W;
    localparam int LW = CW + 1;

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rbin_nxt;
    logic [LW-1:0] fill;
    logic          has_mem;
    logic          take;
    logic          pop;
    logic          ofs_rd;
    logic          valid;
    ofs_sel_e      sel;

    for (genvar i = 0; i < PW; i++) begin : g_dec
        assign wbin_s[i] = ^wgray_s[PW-1:i];
    end

    assign level    = wbin_s - rbin;
    assign has_mem  = (level != '0);
    assign take     = !rd_en_n && load_n;
    assign ofs_rd   = !rd_en_n && !load_n;
    assign rbin_nxt = rbin + PW'(1);
    assign raddr    = rbin[AW-1:0];

    // Fall-through prefetches whenever the output slot is free or being consumed
    always_comb begin
        if (fwft) pop = has_mem && (!valid || take);
        else      pop = has_mem && take;
    end

    assign fill = LW'(level) + LW'(fwft && valid);

    always_comb begin
        st.has_data     = has_mem;
        st.almost_empty = (fill <= LW'(ofs_e));
        st.out_valid    = valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            dreg  <= '0;
            valid <= 1'b0;
        end else begin
            if (pop) begin
                rbin  <= rbin_nxt;
                rgray <= rbin_nxt ^ (rbin_nxt >> 1);
                dreg  <= rdata;
            end
            if (!fwft)       valid <= 1'b0;
            else if (pop)    valid <= 1'b1;
            else if (take)   valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_val   <= '0;
            show_ofs <= 1'b0;
            sel      <= SEL_EMPTY_OFS;
        end else if (ofs_rd) begin
            rb_val   <= (sel == SEL_EMPTY_OFS) ? ofs_e : ofs_f;
            show_ofs <= 1'b1;
            sel      <= next_sel(sel);
        end else if (take) begin
            show_ofs <= 1'b0;
        end
    end
endmodule

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag
    import fifo_pf_pkg::*;
#(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int OFS_W = 12
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_en_n,
    input  logic [DW-1:0] din,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_en_n,
    input  logic          load_n,
    input  logic          fwft,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          q_en,
    output logic          wflag_n,
    output logic          rflag_n,
    output logic          half_n,
    output logic          aempty_n,
    output logic          afull_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [OFS_W-1:0] OFS_INIT = OFS_W'(reset_offset(DEPTH));

    logic             mem_we;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic [DW-1:0]    rdata;
    logic [PW-1:0]    wgray, wgray_r;
    logic [PW-1:0]    rgray, rgray_w;
    logic [PW-1:0]    w_bin, r_bin;
    logic [PW-1:0]    w_level, r_level;
    logic [OFS_W-1:0] ofs_e_w, ofs_f_w, ofs_e_r, ofs_f_r;
    logic [DW-1:0]    r_dreg;
    logic             show_ofs;
    logic [OFS_W-1:0] rb_val;
    wr_status_t       wst;
    rd_status_t       rst_flags;

    fifo_pf_wside #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .OFS_W(OFS_W)) u_wside (
        .clk(wclk), .rst(wrst), .wr_en_n(wr_en_n), .load_n(load_n), .din(din),
        .rgray_s(rgray_w), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
        .wbin(w_bin), .level(w_level), .st(wst), .ofs_e(ofs_e_w), .ofs_f(ofs_f_w)
    );

    fifo_pf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    fifo_pf_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );

    fifo_pf_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );

    fifo_pf_sync2 #(.W(2 * OFS_W), .INIT({OFS_INIT, OFS_INIT})) u_ofs2r (
        .clk(rclk), .rst(rrst), .d({ofs_e_w, ofs_f_w}), .q({ofs_e_r, ofs_f_r})
    );

    fifo_pf_rside #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .OFS_W(OFS_W)) u_rside (
        .clk(rclk), .rst(rrst), .rd_en_n(rd_en_n), .load_n(load_n), .fwft(fwft),
        .wgray_s(wgray_r), .rdata(rdata), .ofs_e(ofs_e_r), .ofs_f(ofs_f_r),
        .raddr(raddr), .rgray(rgray), .rbin(r_bin), .level(r_level),
        .dreg(r_dreg), .show_ofs(show_ofs), .rb_val(rb_val), .st(rst_flags)
    );

    assign wflag_n  = fwft ? wst.full : !wst.full;
    assign rflag_n  = fwft ? !rst_flags.out_valid : rst_flags.has_data;
    assign half_n   = !wst.over_half;
    assign afull_n  = !wst.almost_full;
    assign aempty_n = !rst_flags.almost_empty;

    assign q_en = !oe_n;
    assign q    = oe_n ? '0 : (show_ofs ? DW'(rb_val) : r_dreg);
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
    parameter int DW    = 18,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic          wclk,
    input logic          rclk,
    input logic          wrst,
    input logic          rrst,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          load_n,
    input logic          fwft,
    input logic          oe_n,
    input logic [DW-1:0] q,
    input logic          q_en,
    input logic          wflag_n,
    input logic          rflag_n,
    input logic [AW:0]   w_ptr,
    input logic [AW:0]   r_ptr,
    input logic [AW:0]   w_level,
    input logic [AW:0]   r_level,
    input logic [DW-1:0] r_dreg
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst) w_level <= (AW+1)'(DEPTH)) else $error("write level above depth"); // R5
    AST_RD_LEVEL_BOUND: assert property (@(posedge rclk) disable iff (rrst) r_level <= (AW+1)'(DEPTH)) else $error("read level above depth"); // R4
    AST_FULL_NO_PUSH: assert property (@(posedge wclk) disable iff (wrst) (!fwft && !wflag_n && !wr_en_n) |=> $stable(w_ptr)) else $error("write accepted while full"); // R2
    AST_EMPTY_NO_POP: assert property (@(posedge rclk) disable iff (rrst) (!fwft && !rflag_n && !rd_en_n) |=> $stable(r_ptr)) else $error("read accepted while empty"); // R3
    AST_HOLD_Q: assert property (@(posedge rclk) disable iff (rrst) (!fwft && rd_en_n) |=> $stable(r_dreg)) else $error("output register moved without read"); // R3
    AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (wrst) (!load_n && !wr_en_n) |=> $stable(w_ptr)) else $error("offset load wrote memory"); // R10
    AST_LOAD_NO_POP: assert property (@(posedge rclk) disable iff (rrst) (!fwft && !load_n && !rd_en_n) |=> $stable(r_ptr)) else $error("offset readback popped a word"); // R11
    AST_FWFT_KEEP: assert property (@(posedge rclk) disable iff (rrst) (fwft && !rflag_n && rd_en_n) |=> !rflag_n) else $error("waiting word vanished"); // R12
    AST_OE_OFF: assert property (@(posedge rclk) disable iff (rrst) oe_n |-> (q == '0 && !q_en)) else $error("outputs active while disabled"); // R13
endmodule

bind dcfifo_progflag fifo_pf_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .wrst(wrst), .rrst(rrst),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n), .fwft(fwft),
    .oe_n(oe_n), .q(q), .q_en(q_en), .wflag_n(wflag_n), .rflag_n(rflag_n),
    .w_ptr(w_bin), .r_ptr(r_bin), .w_level(w_level), .r_level(r_level),
    .r_dreg(r_dreg)
);

// File: tb/sim_dcfifo_progflag.sv
module sim_dcfifo_progflag;
    localparam int DW    = 18;
    localparam int DEPTH = 256;
    localparam logic [DW-1:0] VEC [8] = '{
        18'h00000, 18'h3FFFF, 18'h2AAAA, 18'h15555,
        18'h00001, 18'h20000, 18'h0F0F0, 18'h30C3C
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, load_n = 1'b1;
    logic          fwft = 1'b0, oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] q;
    logic          q_en, wflag_n, rflag_n, half_n, aempty_n, afull_n;

    logic          ld1_n = 1'b1, rd1_n = 1'b1;
    logic [DW-1:0] q1;
    logic          q1_en, wf1_n, rf1_n, hf1_n, ae1_n, af1_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    dcfifo_progflag #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .wclk(clk), .wrst(rst), .wr_en_n(wr_en_n), .din(din),
        .rclk(clk), .rrst(rst), .rd_en_n(rd_en_n), .load_n(load_n),
        .fwft(fwft), .oe_n(oe_n), .q(q), .q_en(q_en), .wflag_n(wflag_n),
        .rflag_n(rflag_n), .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
    );

    dcfifo_progflag #(.DW(DW), .DEPTH(512)) u1 (
        .wclk(clk), .wrst(rst), .wr_en_n(1'b1), .din('0),
        .rclk(clk), .rrst(rst), .rd_en_n(rd1_n), .load_n(ld1_n),
        .fwft(1'b0), .oe_n(1'b0), .q(q1), .q_en(q1_en), .wflag_n(wf1_n),
        .rflag_n(rf1_n), .half_n(hf1_n), .aempty_n(ae1_n), .afull_n(af1_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input logic [DW-1:0] d);
        din = d; wr_en_n = 1'b0; cyc(); wr_en_n = 1'b1;
    endtask

    task automatic rd();
        rd_en_n = 1'b0; cyc(); rd_en_n = 1'b1;
    endtask

    task automatic reset_all(input logic mode);
        rst = 1'b1; fwft = mode; idle(3); rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state, standard mode
        reset_all(1'b0);
        check("R1 wflag_n", 32'(wflag_n), 1);
        check("R1 afull_n", 32'(afull_n), 1);
        check("R1 half_n", 32'(half_n), 1);
        check("R1 rflag_n", 32'(rflag_n), 0);
        check("R1 aempty_n", 32'(aempty_n), 0);
        check("R1 q", 32'(q), 0);
        check("R13 q_en on", 32'(q_en), 1);
        idle(3);

        // Default offsets through readback
        load_n = 1'b0;
        rd(); check("R9 empty ofs depth256", 32'(q), 31);
        rd(); check("R9 full ofs depth256", 32'(q), 31);
        load_n = 1'b1;
        check("R11 readback pops nothing", 32'(rflag_n), 0);
        ld1_n = 1'b0; rd1_n = 1'b0;
        cyc(); check("R9 empty ofs depth512", 32'(q1), 63);
        cyc(); check("R9 full ofs depth512", 32'(q1), 63);
        ld1_n = 1'b1; rd1_n = 1'b1;

        // Vector table: write all, then read back in order
        for (int i = 0; i < 8; i++) wr(VEC[i]);
        idle(4);
        check("R3 not empty after writes", 32'(rflag_n), 1);
        for (int i = 0; i < 8; i++) begin
            rd();
            check("R4 order", 32'(q), 32'(VEC[i]));
        end
        check("R3 empty after last read", 32'(rflag_n), 0);
        rd();
        check("R3 read while empty holds q", 32'(q), 32'(VEC[7]));
        idle(2);
        check("R3 idle holds q", 32'(q), 32'(VEC[7]));

        // Fill to full and watch write-side flags
        for (int i = 0; i < DEPTH; i++) begin
            wr(DW'(i));
            if (i + 1 == 128) check("R6 half at 128", 32'(half_n), 1);
            if (i + 1 == 129) check("R6 half at 129", 32'(half_n), 0);
            if (i + 1 == 224) check("R7 afull at 224", 32'(afull_n), 1);
            if (i + 1 == 225) check("R7 afull at 225", 32'(afull_n), 0);
            if (i + 1 == 255) check("R5 full at 255", 32'(wflag_n), 1);
            if (i + 1 == 256) check("R5 full at 256", 32'(wflag_n), 0);
        end
        wr(18'h3FFFF);
        check("R2 still full", 32'(wflag_n), 0);
        idle(4);
        for (int r = 1; r <= DEPTH; r++) begin
            rd();
            check("R4 drain order", 32'(q), 32'(r - 1));
            if (r == 224) check("R8 aempty at 32", 32'(aempty_n), 1);
            if (r == 225) check("R8 aempty at 31", 32'(aempty_n), 0);
        end
        check("R2 empty after depth reads", 32'(rflag_n), 0);
        rd();
        check("R2 dropped word absent", 32'(q), 255);
        idle(4);
        check("R2 still empty", 32'(rflag_n), 0);
        check("R5 full released", 32'(wflag_n), 1);

        // Offset loads: empty offset 5, then full offset 250
        load_n = 1'b0;
        wr(18'h3F005);
        wr(18'h000FA);
        load_n = 1'b1;
        idle(4);
        check("R10 load leaves memory empty", 32'(rflag_n), 0);
        for (int i = 0; i < 5; i++) wr(DW'(18'h100 + i));
        check("R10 afull with free 251", 32'(afull_n), 1);
        idle(4);
        check("R10 aempty at level 5", 32'(aempty_n), 0);
        wr(18'h105);
        check("R10 afull with free 250", 32'(afull_n), 0);
        idle(4);
        check("R10 aempty at level 6", 32'(aempty_n), 1);

        // Readback order and no pop
        load_n = 1'b0;
        rd(); check("R11 readback empty ofs", 32'(q), 5);
        rd(); check("R11 readback full ofs", 32'(q), 250);
        load_n = 1'b1;
        check("R11 level unchanged", 32'(aempty_n), 1);
        rd(); check("R11 data path restored", 32'(q), 32'h100);

        // Output enable
        oe_n = 1'b1; #1;
        check("R13 q zero when disabled", 32'(q), 0);
        check("R13 q_en low", 32'(q_en), 0);
        oe_n = 1'b0; #1;
        check("R13 q_en high", 32'(q_en), 1);
        check("R13 q back", 32'(q), 32'h100);

        // Fall-through mode
        reset_all(1'b1);
        check("R12 no word waiting", 32'(rflag_n), 1);
        check("R12 room available", 32'(wflag_n), 0);
        wr(18'h2AAAA);
        idle(4);
        check("R12 word shown without strobe", 32'(rflag_n), 0);
        check("R12 first word on q", 32'(q), 32'h2AAAA);
        wr(18'h15555);
        idle(4);
        check("R12 q holds without strobe", 32'(q), 32'h2AAAA);
        rd();
        check("R12 strobe advances", 32'(q), 32'h15555);
        check("R12 still ready", 32'(rflag_n), 0);
        rd();
        check("R12 drained", 32'(rflag_n), 1);
        for (int i = 0; i < DEPTH; i++) wr(DW'(i));
        idle(5);
        check("R12 room after prefetch", 32'(wflag_n), 0);
        check("R8 fwft level counts q word", 32'(aempty_n), 1);
        wr(18'h03000);
        check("R12 full in fwft", 32'(wflag_n), 1);
        check("R12 oldest word on q", 32'(q), 0);

        finish_run();
    end
endmodule